// File: doc/BRIEF.md
# FEC Codeword Framing Sequencer

This block steps through the byte slots of each DMT data frame and says, for every slot, whether it carries payload or a Reed-Solomon check byte, and whether a codeword begins or ends there. It handles three codeword arrangements: several whole codewords packed into one frame, exactly one codeword per frame, and on the interleaved path one codeword spread over up to 20 consecutive frames. It also counts frames within a superframe (68 data frames followed by one sync frame that carries no codeword bytes) and counts superframes. Codeword position is never realigned at a superframe boundary, so a codeword may straddle the sync frame.

The programmed codeword length, check-byte count, frame data length, frames-per-codeword value and path selection are validated continuously. An illegal combination drives the sequencer into an error state where it emits nothing. Once the settings become legal again it restarts from an empty codeword and waits for a frame strobe. Each accepted slot strobe produces a one-cycle group of output flags on the following clock cycle.

The state machine has five states. `S_IDLE` waits for the first validation result, then moves to `S_WAIT` if legal or to `S_ERR` if not. `S_WAIT` moves to `S_DATA` on the first frame strobe, which becomes frame 0. `S_DATA` moves to `S_SYNC` on the frame strobe that follows frame 67. `S_SYNC` returns to `S_DATA` on the next frame strobe. Any state except `S_IDLE` moves to `S_ERR` when the settings turn illegal. `S_ERR` returns to `S_IDLE` when they turn legal.

Top module: `fec_frame_seq`

## Requirements
- R1: `cfg_mode` reports 0 (several codewords per frame) when frames-per-codeword is 1 and the codeword length divides the frame length and is smaller than it. It reports 1 (one per frame) when frames-per-codeword is 1 and the two lengths are equal. It reports 2 (spread) when frames-per-codeword is 2..20, the interleaved path is selected, and the codeword length equals frames-per-codeword times the frame length.
- R2: Any other combination is illegal and yields `cfg_mode` = 3, `cfg_err` = 1 and no byte strobes. Illegal cases include a zero length, check bytes not fewer than the codeword length, frames-per-codeword above 20, spreading on the fast path, and a check count that is not a multiple of frames-per-codeword.
- R3: An accepted slot strobe gives a one-cycle `byte_vld` on the next cycle. With frames-per-codeword of 1, `byte_chk` marks the last (check count) positions of each codeword.
- R4: In spread mode each frame holds one share of (frame length) bytes, and `byte_chk` marks the last (check count / frames-per-codeword) slots of every share.
- R5: `cw_sop` is high with the first byte of a codeword and `cw_eop` with its last, each for one cycle together with `byte_vld`.
- R6: The first frame strobe after arming gives `frame_idx` 0. Each later strobe increments it, and after index 68 it wraps to 0 while `sframe_cnt` increments.
- R7: Frame index 68 is the sync frame. `sync_frame` is high during it and its slot strobes produce no output.
- R8: Codeword position carries through the sync frame and across superframes without realignment.
- R9: Slot strobes are ignored before the first frame strobe, beyond the frame length, and in the same cycle as a frame strobe.
- R10: During reset all strobes, `frame_idx`, `sframe_cnt`, `sync_frame` and `cfg_err` read 0 and `cfg_mode` reads 3.
- R11: If the settings turn illegal while running, `cfg_err` rises within two cycles. When they are legal again, the block rearms and the next codeword starts at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_len | input | LEN_W | Codeword length in bytes, check bytes included |
| chk_len | input | LEN_W | Check bytes per codeword |
| frm_len | input | LEN_W | Data bytes per frame on the selected path |
| fpc | input | FPC_W | Frames per codeword |
| path_il | input | 1 | 1 = interleaved path, 0 = fast path |
| frame_start | input | 1 | One-cycle frame boundary strobe |
| slot_stb | input | 1 | One-cycle byte slot strobe |
| byte_vld | output | 1 | Slot carried a codeword byte |
| byte_chk | output | 1 | That byte is a check byte |
| cw_sop | output | 1 | First byte of a codeword |
| cw_eop | output | 1 | Last byte of a codeword |
| frame_idx | output | 7 | Frame index within the superframe |
| sframe_cnt | output | SF_W | Superframe count |
| sync_frame | output | 1 | Current frame is the sync frame |
| cfg_err | output | 1 | Illegal settings, sequencer halted |
| cfg_mode | output | 2 | Codeword arrangement: 0 several, 1 single, 2 spread, 3 none |

## Verification
The hardest case to reach is a codeword that straddles the sync frame. It takes 69 frame strobes before the boundary appears, and only if the frame count per superframe is not a multiple of the frames per codeword. The stimulus uses spread mode with three two-byte shares, so 68 data frames leave the current codeword two-thirds done. It then walks all 71 frames and checks that the first frame of the next superframe resumes mid-codeword and ends that codeword on its second byte.

// File: rtl/fec_seq_pkg.sv
`timescale 1ns/1ps
package fec_seq_pkg;
    localparam int SF_DATA_FRAMES = 68;
    localparam int SYNC_IDX       = SF_DATA_FRAMES;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_DATA,
        S_SYNC,
        S_ERR
    } seq_state_t;

    typedef enum logic [1:0] {
        M_MULTI  = 2'd0,
        M_SINGLE = 2'd1,
        M_SPAN   = 2'd2,
        M_NONE   = 2'd3
    } cw_mode_t;
endpackage

// File: rtl/fec_cfg_check.sv
`timescale 1ns/1ps
module fec_cfg_check
    import fec_seq_pkg::*;
#(
    parameter int LEN_W   = 9,
    parameter int FPC_W   = 5,
    parameter int MAX_FPC = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] cw_len,
    input  logic [LEN_W-1:0] chk_len,
    input  logic [LEN_W-1:0] frm_len,
    input  logic [FPC_W-1:0] fpc,
    input  logic             path_il,
    output logic             cfg_vld,
    output logic             cfg_ok,
    output cw_mode_t         mode,
    output logic [LEN_W-1:0] share_len,
    output logic [LEN_W-1:0] share_chk
);
    localparam int PROD_W = LEN_W + FPC_W;

    cw_mode_t         mode_c;
    logic [LEN_W-1:0] shl_c;
    logic [LEN_W-1:0] shc_c;
    logic [PROD_W-1:0] prod;

    always_comb begin
        mode_c = M_NONE;
        shl_c  = '0;
        shc_c  = '0;
        prod   = PROD_W'(fpc) * PROD_W'(frm_len);
        if (cw_len == '0 || frm_len == '0 || fpc == '0 ||
            fpc > FPC_W'(MAX_FPC) || chk_len >= cw_len) begin
            mode_c = M_NONE;
        end else if (fpc == FPC_W'(1)) begin
            if ((frm_len % cw_len) == '0) begin
                mode_c = (cw_len == frm_len) ? M_SINGLE : M_MULTI;
                shl_c  = cw_len;
                shc_c  = chk_len;
            end
        end else if (path_il && ((chk_len % LEN_W'(fpc)) == '0) &&
                     (prod == PROD_W'(cw_len))) begin
            mode_c = M_SPAN;
            shl_c  = frm_len;
            shc_c  = chk_len / LEN_W'(fpc);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_vld   <= 1'b0;
            cfg_ok    <= 1'b0;
            mode      <= M_NONE;
            share_len <= '0;
            share_chk <= '0;
        end else begin
            cfg_vld   <= 1'b1;
            cfg_ok    <= (mode_c != M_NONE);
            mode      <= mode_c;
            share_len <= shl_c;
            share_chk <= shc_c;
        end
    end
endmodule

// File: rtl/fec_frame_track.sv
`timescale 1ns/1ps
module fec_frame_track
    import fec_seq_pkg::*;
#(
    parameter int FIDX_W = 7,
    parameter int SF_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              first,
    input  logic              adv,
    output logic [FIDX_W-1:0] fidx,
    output logic [SF_W-1:0]   sfcnt,
    output logic              last_data
);
    assign last_data = (fidx == FIDX_W'(SYNC_IDX - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fidx  <= '0;
            sfcnt <= '0;
        end else if (first) begin
            fidx <= '0;
        end else if (adv) begin
            if (fidx == FIDX_W'(SYNC_IDX)) begin
                fidx  <= '0;
                sfcnt <= sfcnt + SF_W'(1);
            end else begin
                fidx <= fidx + FIDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/fec_cw_pos.sv
`timescale 1ns/1ps
module fec_cw_pos #(
    parameter int LEN_W = 9,
    parameter int FPC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [LEN_W-1:0] share_len,
    input  logic [LEN_W-1:0] share_chk,
    input  logic [FPC_W-1:0] fpc,
    output logic             is_chk,
    output logic             is_sop,
    output logic             is_eop
);
    logic [LEN_W-1:0] sp;
    logic [FPC_W-1:0] si;
    logic             sp_last;
    logic             si_last;

    assign sp_last = (sp == share_len - LEN_W'(1));
    assign si_last = (si == fpc - FPC_W'(1));
    assign is_chk  = (sp >= share_len - share_chk);
    assign is_sop  = (sp == '0) && (si == '0);
    assign is_eop  = sp_last && si_last;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sp <= '0;
            si <= '0;
        end else if (step) begin
            if (sp_last) begin
                sp <= '0;
                si <= si_last ? '0 : si + FPC_W'(1);
            end else begin
                sp <= sp + LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/fec_frame_seq.sv
`timescale 1ns/1ps
module fec_frame_seq
    import fec_seq_pkg::*;
#(
    parameter int LEN_W   = 9,
    parameter int FPC_W   = 5,
    parameter int MAX_FPC = 20,
    parameter int SF_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] cw_len,
    input  logic [LEN_W-1:0] chk_len,
    input  logic [LEN_W-1:0] frm_len,
    input  logic [FPC_W-1:0] fpc,
    input  logic             path_il,
    input  logic             frame_start,
    input  logic             slot_stb,
    output logic             byte_vld,
    output logic             byte_chk,
    output logic             cw_sop,
    output logic             cw_eop,
    output logic [6:0]       frame_idx,
    output logic [SF_W-1:0]  sframe_cnt,
    output logic             sync_frame,
    output logic             cfg_err,
    output logic [1:0]       cfg_mode
);
    localparam int FIDX_W = $clog2(SYNC_IDX + 1);

    seq_state_t       fsm_q;
    seq_state_t       fsm_d;
    logic             cfg_vld;
    logic             cfg_ok;
    cw_mode_t         mode_q;
    logic [LEN_W-1:0] share_len;
    logic [LEN_W-1:0] share_chk;
    logic [LEN_W-1:0] slot_cnt;
    logic             last_data;
    logic             accept;
    logic             pos_clr;
    logic             trk_first;
    logic             trk_adv;
    logic             p_chk;
    logic             p_sop;
    logic             p_eop;
    logic [FIDX_W-1:0] fidx;

    fec_cfg_check #(.LEN_W(LEN_W), .FPC_W(FPC_W), .MAX_FPC(MAX_FPC)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cw_len(cw_len), .chk_len(chk_len),
        .frm_len(frm_len), .fpc(fpc), .path_il(path_il),
        .cfg_vld(cfg_vld), .cfg_ok(cfg_ok), .mode(mode_q),
        .share_len(share_len), .share_chk(share_chk)
    );

    assign pos_clr   = (fsm_q == S_IDLE) || (fsm_q == S_ERR);
    assign trk_first = (fsm_q == S_WAIT) && frame_start && cfg_ok;
    assign trk_adv   = ((fsm_q == S_DATA) || (fsm_q == S_SYNC)) && frame_start && cfg_ok;
    assign accept    = (fsm_q == S_DATA) && cfg_ok && slot_stb && !frame_start &&
                       (slot_cnt < frm_len);

    fec_frame_track #(.FIDX_W(FIDX_W), .SF_W(SF_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .clr(pos_clr), .first(trk_first),
        .adv(trk_adv), .fidx(fidx), .sfcnt(sframe_cnt), .last_data(last_data)
    );

    fec_cw_pos #(.LEN_W(LEN_W), .FPC_W(FPC_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .clr(pos_clr), .step(accept),
        .share_len(share_len), .share_chk(share_chk), .fpc(fpc),
        .is_chk(p_chk), .is_sop(p_sop), .is_eop(p_eop)
    );

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            S_IDLE: if (cfg_vld) fsm_d = cfg_ok ? S_WAIT : S_ERR;
            S_WAIT: begin
                if (!cfg_ok)          fsm_d = S_ERR;
                else if (frame_start) fsm_d = S_DATA;
            end
            S_DATA: begin
                if (!cfg_ok)                       fsm_d = S_ERR;
                else if (frame_start && last_data) fsm_d = S_SYNC;
            end
            S_SYNC: begin
                if (!cfg_ok)          fsm_d = S_ERR;
                else if (frame_start) fsm_d = S_DATA;
            end
            S_ERR:  if (cfg_ok) fsm_d = S_IDLE;
            default: fsm_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= S_IDLE;
        else        fsm_q <= fsm_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_cnt <= '0;
            byte_vld <= 1'b0;
            byte_chk <= 1'b0;
            cw_sop   <= 1'b0;
            cw_eop   <= 1'b0;
        end else begin
            if (frame_start || fsm_q != S_DATA) slot_cnt <= '0;
            else if (accept)                    slot_cnt <= slot_cnt + LEN_W'(1);
            byte_vld <= accept;
            byte_chk <= accept && p_chk;
            cw_sop   <= accept && p_sop;
            cw_eop   <= accept && p_eop;
        end
    end

    assign frame_idx  = 7'(fidx);
    assign sync_frame = (fsm_q == S_SYNC);
    assign cfg_err    = (fsm_q == S_ERR);
    assign cfg_mode   = mode_q;
endmodule

// File: rtl/fec_frame_seq_chk.sv
`timescale 1ns/1ps
module fec_frame_seq_chk
    import fec_seq_pkg::*;
#(
    parameter int SF_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input seq_state_t      fsm_q,
    input logic            byte_vld,
    input logic            byte_chk,
    input logic            cw_sop,
    input logic            cw_eop,
    input logic [6:0]      frame_idx,
    input logic [SF_W-1:0] sframe_cnt,
    input logic            sync_frame,
    input logic            cfg_err
);
    assert_vld_from_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(fsm_q) == S_DATA);

    assert_flags_need_vld_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_chk || cw_sop || cw_eop) |-> byte_vld);

    assert_err_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && $past(cfg_err)) |-> !byte_vld);

    assert_frame_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_idx <= 7'(SYNC_IDX));

    assert_sf_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sframe_cnt != $past(sframe_cnt) && !$past(cfg_err)) |->
            ($past(frame_idx) == 7'(SYNC_IDX) && frame_idx == 7'd0));

    assert_sync_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_frame |-> frame_idx == 7'(SYNC_IDX));

    assert_sync_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_frame && $past(sync_frame)) |-> !byte_vld);
endmodule

bind fec_frame_seq fec_frame_seq_chk #(.SF_W(SF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fsm_q(fsm_q), .byte_vld(byte_vld),
    .byte_chk(byte_chk), .cw_sop(cw_sop), .cw_eop(cw_eop),
    .frame_idx(frame_idx), .sframe_cnt(sframe_cnt),
    .sync_frame(sync_frame), .cfg_err(cfg_err)
);

// File: tb/fec_frame_seq_bench.sv
`timescale 1ns/1ps
module fec_frame_seq_bench;
    typedef struct packed {
        logic [8:0] cw;
        logic [8:0] chk;
        logic [8:0] flen;
        logic [4:0] fpc;
        logic       il;
        logic [1:0] mode;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{9'd8,  9'd2,  9'd16, 5'd1,  1'b0, 2'd0},
        '{9'd10, 9'd4,  9'd10, 5'd1,  1'b1, 2'd1},
        '{9'd12, 9'd4,  9'd3,  5'd4,  1'b1, 2'd2},
        '{9'd6,  9'd0,  9'd6,  5'd1,  1'b0, 2'd1},
        '{9'd12, 9'd4,  9'd3,  5'd4,  1'b0, 2'd3},
        '{9'd12, 9'd6,  9'd3,  5'd4,  1'b1, 2'd3},
        '{9'd7,  9'd2,  9'd16, 5'd1,  1'b0, 2'd3},
        '{9'd8,  9'd8,  9'd8,  5'd1,  1'b0, 2'd3},
        '{9'd42, 9'd21, 9'd2,  5'd21, 1'b1, 2'd3},
        '{9'd40, 9'd20, 9'd2,  5'd20, 1'b1, 2'd2},
        '{9'd12, 9'd4,  9'd4,  5'd4,  1'b1, 2'd3},
        '{9'd0,  9'd0,  9'd4,  5'd1,  1'b0, 2'd3}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] cw_len = '0, chk_len = '0, frm_len = '0;
    logic [4:0] fpc = '0;
    logic       path_il = 1'b0, frame_start = 1'b0, slot_stb = 1'b0;
    logic       byte_vld, byte_chk, cw_sop, cw_eop, sync_frame, cfg_err;
    logic [6:0] frame_idx;
    logic [7:0] sframe_cnt;
    logic [1:0] cfg_mode;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int m_sp, m_si, m_share, m_schk, m_fpc;

    always #4 clk = ~clk;  // 125 MHz

    fec_frame_seq u_fec_frame_seq (
        .clk(clk), .rst_n(rst_n), .cw_len(cw_len), .chk_len(chk_len),
        .frm_len(frm_len), .fpc(fpc), .path_il(path_il),
        .frame_start(frame_start), .slot_stb(slot_stb),
        .byte_vld(byte_vld), .byte_chk(byte_chk), .cw_sop(cw_sop),
        .cw_eop(cw_eop), .frame_idx(frame_idx), .sframe_cnt(sframe_cnt),
        .sync_frame(sync_frame), .cfg_err(cfg_err), .cfg_mode(cfg_mode)
    );

    task automatic check(input string rq, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
        end
    endtask

    task automatic set_cfg(input vec_t v);
        cw_len = v.cw; chk_len = v.chk; frm_len = v.flen; fpc = v.fpc; path_il = v.il;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; frame_start = 1'b0; slot_stb = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R10", byte_vld | byte_chk | cw_sop | cw_eop, 0);
        check("R10", frame_idx, 0);
        check("R10", sframe_cnt, 0);
        check("R10", sync_frame | cfg_err, 0);
        check("R10", cfg_mode, 3);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_frame();
        @(negedge clk) frame_start = 1'b1;
        @(posedge clk);
        @(negedge clk) frame_start = 1'b0;
    endtask

    task automatic do_slot(output logic v, output logic c, output logic s, output logic e);
        @(negedge clk) slot_stb = 1'b1;
        @(posedge clk);
        #1;
        v = byte_vld; c = byte_chk; s = cw_sop; e = cw_eop;
        @(negedge clk) slot_stb = 1'b0;
    endtask

    task automatic model_load(input vec_t v);
        m_sp = 0; m_si = 0; m_fpc = v.fpc;
        m_share = (v.mode == 2) ? v.flen : v.cw;
        m_schk  = (v.mode == 2) ? v.chk / v.fpc : v.chk;
    endtask

    task automatic slot_check(input string rq, output logic s, output logic c);
        logic v, e;
        do_slot(v, c, s, e);
        check(rq, v, 1);
        check(rq, c, (m_sp >= m_share - m_schk) ? 1 : 0);
        check("R5", s, (m_sp == 0 && m_si == 0) ? 1 : 0);
        check("R5", e, (m_sp == m_share - 1 && m_si == m_fpc - 1) ? 1 : 0);
        if (m_sp == m_share - 1) begin
            m_sp = 0;
            m_si = (m_si == m_fpc - 1) ? 0 : m_si + 1;
        end else begin
            m_sp++;
        end
    endtask

    initial begin
        logic v, c, s, e;
        int nfr;
        // Table walk: classification and per-slot flags
        for (int k = 0; k < NVEC; k++) begin
            set_cfg(VECS[k]);
            do_reset();
            check("R1", cfg_mode, VECS[k].mode);
            check("R2", cfg_err, (VECS[k].mode == 2'd3) ? 1 : 0);
            if (VECS[k].mode == 2'd3) begin
                do_frame();
                for (int j = 0; j < 3; j++) begin
                    do_slot(v, c, s, e);
                    check("R2", v, 0);
                end
            end else begin
                model_load(VECS[k]);
                nfr = (VECS[k].fpc > 1) ? VECS[k].fpc + 1 : 3;
                for (int f = 0; f < nfr; f++) begin
                    do_frame();
                    check("R6", frame_idx, f);
                    for (int j = 0; j < VECS[k].flen; j++)
                        slot_check((VECS[k].mode == 2'd2) ? "R4" : "R3", s, c);
                end
            end
        end

        // Sync frame and superframe crossing (R6 R7 R8)
        set_cfg('{9'd6, 9'd3, 9'd2, 5'd3, 1'b1, 2'd2});
        do_reset();
        model_load('{9'd6, 9'd3, 9'd2, 5'd3, 1'b1, 2'd2});
        for (int f = 0; f < 71; f++) begin
            do_frame();
            check("R6", frame_idx, (f <= 68) ? f : f - 69);
            if (f == 68) begin
                check("R7", sync_frame, 1);
                for (int j = 0; j < 2; j++) begin
                    do_slot(v, c, s, e);
                    check("R7", v, 0);
                end
            end else begin
                check("R7", sync_frame, 0);
                for (int j = 0; j < 2; j++) begin
                    slot_check("R4", s, c);
                    if (f == 69 && j == 0) begin
                        check("R8", s, 0);
                        check("R8", c, 0);
                    end
                    if (f == 69 && j == 1) check("R8", c, 1);
                end
            end
            if (f == 69) check("R6", sframe_cnt, 1);
        end

        // Ignored slots (R9)
        set_cfg(VECS[0]);
        do_reset();
        model_load(VECS[0]);
        do_slot(v, c, s, e);
        check("R9", v, 0);
        do_frame();
        for (int j = 0; j < 16; j++) slot_check("R3", s, c);
        do_slot(v, c, s, e);
        check("R9", v, 0);
        @(negedge clk) begin frame_start = 1'b1; slot_stb = 1'b1; end
        @(posedge clk);
        #1 check("R9", byte_vld, 0);
        @(negedge clk) begin frame_start = 1'b0; slot_stb = 1'b0; end
        do_slot(v, c, s, e);
        check("R9", s, 1);

        // Live error and recovery (R11)
        do_slot(v, c, s, e);
        chk_len = 9'd8;
        @(posedge clk); @(posedge clk);
        #1 check("R11", cfg_err, 1);
        do_slot(v, c, s, e);
        check("R11", v, 0);
        @(negedge clk) chk_len = 9'd2;
        repeat (3) @(posedge clk);
        #1 check("R11", cfg_err, 0);
        check("R11", cfg_mode, 0);
        do_frame();
        check("R11", frame_idx, 0);
        do_slot(v, c, s, e);
        check("R11", s, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule